// File: doc/BRIEF.md
# I2C Ten-Bit Slave Address Matcher

This block makes the acknowledge decision for the address phase of an I2C slave whose own address is ten bits wide. A separate bit-level engine samples the bus. It passes this block one-cycle pulses for START, repeated START and STOP, and it raises a strobe with each received byte. The matcher compares the address bytes with the configured own address. Its outputs are an acknowledge decision, an "addressed" flag, a transmit-direction flag and a general-call flag.

A ten-bit address takes two bytes. The first byte holds the fixed pattern 11110 in bits 7:3, the two upper own-address bits in bits 2:1 and the read/write bit in bit 0. The second byte holds the lower eight own-address bits. The matcher also remembers that a full write-direction match has happened. Because of that memory, after a repeated START the master can resend only the first byte with the read bit set, and the slave becomes a transmitter. The engine uses `ack` to drive the acknowledge bit of address bytes. It uses `addressed` and `tx_mode` to handle the data phase.

Top module: `tenbit_addr_match`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs and the remembered-match memory are cleared at that edge (synchronous, active-low).
- R2: In the first byte after START or repeated START, the value {11110, own[9:8], 0} (bit 0 is the read/write bit, 0 = write) is acknowledged. No other value is acknowledged unless R6 or R8 applies.
- R3: In the byte that follows an acknowledged write-direction first byte, a value equal to own[7:0] is acknowledged and sets `addressed`=1, `tx_mode`=0, `gen_call`=0. Any other value is not acknowledged and clears `addressed`.
- R4: `ack` is registered. It takes the decision for a byte on the cycle after that byte's strobe. It holds the value until the next strobe. It goes to 0 on the cycle after any START, repeated START or STOP pulse.
- R5: STOP clears `ack`, `addressed`, `tx_mode`, `gen_call` and the remembered match. After STOP, a repeated START with a read-direction first byte is not acknowledged.
- R6: After a full ten-bit write match and then a repeated START, the first byte {11110, own[9:8], 1} is acknowledged and sets `addressed`=1 and `tx_mode`=1 without a second address byte.
- R7: After a plain START, with no earlier match, the read-direction first byte {11110, own[9:8], 1} is not acknowledged.
- R8: With `gc_enable`=1, a first byte of 0x00 is acknowledged and sets `addressed`=1, `gen_call`=1 and `tx_mode`=0.
- R9: With `gc_enable`=0, a first byte of 0x00 is not acknowledged, and the bytes that follow it are not acknowledged.
- R10: After a first byte that matches nothing, every byte is not acknowledged until the next START or repeated START.
- R11: Across a repeated START, `addressed` holds its value until the first byte is judged. A different address after the repeated START, which includes a general call, clears the remembered match. A later repeated START with a read-direction first byte is then not acknowledged.
- R12: Data bytes received while addressed get `ack`=0 from this block and leave `addressed`, `tx_mode` and `gen_call` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 10 | Own ten-bit slave address |
| gc_enable | input | 1 | Answer the general-call address |
| start_p | input | 1 | START seen (one-cycle pulse) |
| rstart_p | input | 1 | Repeated START seen (one-cycle pulse) |
| stop_p | input | 1 | STOP seen (one-cycle pulse) |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte value |
| ack | output | 1 | Acknowledge decision for the last address byte |
| addressed | output | 1 | Slave is currently addressed |
| tx_mode | output | 1 | Addressed as transmitter |
| gen_call | output | 1 | Addressed by a general call |

## Verification
The remembered-match bit cannot be seen directly at the ports. If it is wrong, the error shows only on the first read-direction byte after a repeated START, one cycle after that byte's strobe: `ack` and `tx_mode` are acknowledged when they should not be, or the reverse. If the phase state is wrong, `ack` shows it on the cycle after the next byte strobe. The main examples are a second byte judged as a first byte, or bytes still acknowledged after a mismatch. The bench sweeps every byte value through each address position for two own addresses and both general-call settings, so each such divergence reaches a port within one byte.

// File: rtl/tam_pkg.sv
// Package: shared constants and types for the ten-bit address matcher.
// Assumes the standard ten-bit prefix; widths are fixed by the protocol.
package tam_pkg;
    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

    // Address-phase position of the matcher.
    typedef enum logic [2:0] {
        PH_IDLE,     // no address phase open, NACK everything
        PH_WAIT_HI,  // next byte is a first address byte
        PH_WAIT_LO,  // next byte is the low address byte
        PH_ADDR,     // addressed, data phase
        PH_IGNORE    // mismatch seen, NACK until next (repeated) START
    } phase_t;

    // Per-byte comparison results.
    typedef struct packed {
        logic hi_wr;  // first byte, own upper bits, write
        logic hi_rd;  // first byte, own upper bits, read
        logic gcall;  // all-zero byte
        logic lo;     // equals own low eight bits
    } hit_t;
endpackage

// File: rtl/tam_addr_cmp.sv
// Module: tam_addr_cmp
// Combinational comparison of one received byte against every address
// pattern the matcher can accept. Assumes ADDR_W > BYTE_W and that the
// prefix plus the upper address bits fill BYTE_W-1 bits.
module tam_addr_cmp
    import tam_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] byte_data,
    output hit_t              hit
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int KEY_W = BYTE_W - 1;

    logic [KEY_W-1:0] hi_key;

    // Build the seven-bit first-byte key from prefix and upper own bits.
    always_comb begin
        hi_key = {TEN_BIT_PREFIX, own_addr[ADDR_W-1 -: HI_W]};
    end

    // Classify the received byte.
    always_comb begin
        hit.hi_wr = (byte_data[BYTE_W-1:1] == hi_key) && !byte_data[0];
        hit.hi_rd = (byte_data[BYTE_W-1:1] == hi_key) &&  byte_data[0];
        hit.gcall = (byte_data == '0);
        hit.lo    = (byte_data == own_addr[BYTE_W-1:0]);
    end

    initial begin
        if (KEY_W != 5 + HI_W) $error("tam_addr_cmp: width mismatch");
    end
endmodule

// File: rtl/tam_match_fsm.sv
// Module: tam_match_fsm
// Address-phase sequencer: tracks which address byte is expected, holds
// the acknowledge decision and the addressed/direction/general-call flags,
// and keeps the remembered-match bit that lets a repeated START switch to
// transmit. Assumes bus-condition pulses and byte strobes are one cycle
// wide; if several arrive together STOP wins, then START, then repeated
// START, then the byte.
module tam_match_fsm
    import tam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gc_enable,
    input  logic start_p,
    input  logic rstart_p,
    input  logic stop_p,
    input  logic byte_vld,
    input  hit_t hit,
    output logic ack,
    output logic addressed,
    output logic tx_mode,
    output logic gen_call
);
    phase_t ph_q, ph_d;
    logic   mem_q, mem_d;
    logic   ack_d, adr_d, tx_d, gc_d;

    // Next-state and next-flag decision for the current event.
    always_comb begin
        ph_d  = ph_q;
        mem_d = mem_q;
        ack_d = ack;
        adr_d = addressed;
        tx_d  = tx_mode;
        gc_d  = gen_call;
        if (stop_p) begin
            ph_d  = PH_IDLE;
            mem_d = 1'b0;
            ack_d = 1'b0;
            adr_d = 1'b0;
            tx_d  = 1'b0;
            gc_d  = 1'b0;
        end else if (start_p) begin
            ph_d  = PH_WAIT_HI;
            mem_d = 1'b0;
            ack_d = 1'b0;
            adr_d = 1'b0;
            tx_d  = 1'b0;
            gc_d  = 1'b0;
        end else if (rstart_p) begin
            ph_d  = PH_WAIT_HI;
            ack_d = 1'b0;
        end else if (byte_vld) begin
            ack_d = 1'b0;
            unique case (ph_q)
                PH_WAIT_HI: begin
                    if (hit.hi_wr) begin
                        ack_d = 1'b1;
                        ph_d  = PH_WAIT_LO;
                    end else if (hit.hi_rd && mem_q) begin
                        ack_d = 1'b1;
                        adr_d = 1'b1;
                        tx_d  = 1'b1;
                        gc_d  = 1'b0;
                        ph_d  = PH_ADDR;
                    end else if (hit.gcall && gc_enable) begin
                        ack_d = 1'b1;
                        adr_d = 1'b1;
                        tx_d  = 1'b0;
                        gc_d  = 1'b1;
                        mem_d = 1'b0;
                        ph_d  = PH_ADDR;
                    end else begin
                        adr_d = 1'b0;
                        tx_d  = 1'b0;
                        gc_d  = 1'b0;
                        mem_d = 1'b0;
                        ph_d  = PH_IGNORE;
                    end
                end
                PH_WAIT_LO: begin
                    if (hit.lo) begin
                        ack_d = 1'b1;
                        adr_d = 1'b1;
                        tx_d  = 1'b0;
                        gc_d  = 1'b0;
                        mem_d = 1'b1;
                        ph_d  = PH_ADDR;
                    end else begin
                        adr_d = 1'b0;
                        tx_d  = 1'b0;
                        gc_d  = 1'b0;
                        mem_d = 1'b0;
                        ph_d  = PH_IGNORE;
                    end
                end
                default: begin
                    ph_d = ph_q;
                end
            endcase
        end
    end

    // State and output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            mem_q     <= 1'b0;
            ack       <= 1'b0;
            addressed <= 1'b0;
            tx_mode   <= 1'b0;
            gen_call  <= 1'b0;
        end else begin
            ph_q      <= ph_d;
            mem_q     <= mem_d;
            ack       <= ack_d;
            addressed <= adr_d;
            tx_mode   <= tx_d;
            gen_call  <= gc_d;
        end
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!ack && !addressed && !tx_mode && !gen_call)); // R5
    AST_ACK_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(byte_vld)); // R4
    AST_COND_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p || rstart_p) |=> !ack); // R4
    AST_TX_NEEDS_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_mode) |-> $past(mem_q)); // R6
    AST_TX_IS_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode |-> (addressed && !gen_call)); // R6
    AST_GC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_call) |-> $past(gc_enable)); // R8
    AST_IGNORE_NACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IGNORE && byte_vld) |=> !ack); // R10
endmodule

// File: rtl/tenbit_addr_match.sv
// Module: tenbit_addr_match (top)
// Byte-level ten-bit I2C slave address matcher with optional general-call
// response. Assumes a bit engine that delivers condition pulses and byte
// strobes synchronous to clk; it acts on ack for address bytes only.
module tenbit_addr_match #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_enable,
    input  logic              start_p,
    input  logic              rstart_p,
    input  logic              stop_p,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              ack,
    output logic              addressed,
    output logic              tx_mode,
    output logic              gen_call
);
    tam_pkg::hit_t hit;

    tam_addr_cmp #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_cmp (
        .own_addr  (own_addr),
        .byte_data (byte_data),
        .hit       (hit)
    );

    tam_match_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gc_enable (gc_enable),
        .start_p   (start_p),
        .rstart_p  (rstart_p),
        .stop_p    (stop_p),
        .byte_vld  (byte_vld),
        .hit       (hit),
        .ack       (ack),
        .addressed (addressed),
        .tx_mode   (tx_mode),
        .gen_call  (gen_call)
    );
endmodule

// File: tb/tenbit_addr_match_tb.sv
`timescale 1ns/1ps
module tenbit_addr_match_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] own_addr = '0;
    logic       gc_enable = 1'b0;
    logic       start_p = 1'b0, rstart_p = 1'b0, stop_p = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       ack, addressed, tx_mode, gen_call;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  cur_b = 0;

    always #4 clk = ~clk;

    tenbit_addr_match u_dut (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .gc_enable(gc_enable),
        .start_p(start_p), .rstart_p(rstart_p), .stop_p(stop_p),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .ack(ack), .addressed(addressed), .tx_mode(tx_mode), .gen_call(gen_call)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b (own=%h gc=%0b byte=%h)",
                     tag, what, act, exp, own_addr, gc_enable, cur_b[7:0]);
        end
    endtask

    // All drive tasks start and end at a falling edge.
    task automatic cond_stop();
        stop_p = 1'b1; @(negedge clk); stop_p = 1'b0;
    endtask
    task automatic cond_start();
        start_p = 1'b1; @(negedge clk); start_p = 1'b0;
    endtask
    task automatic cond_rstart();
        rstart_p = 1'b1; @(negedge clk); rstart_p = 1'b0;
    endtask
    task automatic send(input logic [7:0] b);
        byte_data = b; byte_vld = 1'b1; @(negedge clk); byte_vld = 1'b0;
    endtask

    initial begin
        logic [7:0] hw, hr, lo;
        repeat (3) @(negedge clk);
        chk("R1", "ack after reset", ack, 1'b0);
        chk("R1", "addressed after reset", addressed, 1'b0);
        chk("R1", "tx after reset", tx_mode, 1'b0);
        chk("R1", "gc after reset", gen_call, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int oi = 0; oi < 2; oi++) begin
            own_addr = (oi == 0) ? 10'h2A5 : 10'h15A;
            hw = {5'b11110, own_addr[9:8], 1'b0};
            hr = {5'b11110, own_addr[9:8], 1'b1};
            lo = own_addr[7:0];
            for (int g = 0; g < 2; g++) begin
                gc_enable = g[0];
                // Sweep A: every first byte after a plain START.
                for (int b = 0; b < 256; b++) begin
                    logic gc_hit;
                    cur_b = b;
                    gc_hit = (b == 0) && (g == 1);
                    cond_stop(); cond_start();
                    chk("R4", "ack cleared by START", ack, 1'b0);
                    send(b[7:0]);
                    chk((b == 0) ? "R9" : ((b == hr) ? "R7" : "R2"), "first byte ack",
                        ack, (b == hw) || gc_hit);
                    chk("R8", "gc flag", gen_call, gc_hit);
                    chk("R8", "addressed by gc", addressed, gc_hit);
                    send(lo);
                    chk((b == 0) ? "R9" : "R10", "follow-up ack", ack, (b == hw));
                end
                // Sweep B: every second byte after a good first byte.
                for (int b = 0; b < 256; b++) begin
                    cur_b = b;
                    cond_stop(); cond_start();
                    send(hw);
                    chk("R2", "write first byte ack", ack, 1'b1);
                    send(b[7:0]);
                    chk("R3", "second byte ack", ack, (b == lo));
                    chk("R3", "addressed", addressed, (b == lo));
                    chk("R3", "rx mode", tx_mode, 1'b0);
                    send(8'h55);
                    chk((b == lo) ? "R12" : "R10", "data byte ack", ack, 1'b0);
                    chk("R12", "addressed held", addressed, (b == lo));
                end
                // Sweep C: every first byte after repeated START with memory.
                for (int b = 0; b < 256; b++) begin
                    logic gc_hit;
                    cur_b = b;
                    gc_hit = (b == 0) && (g == 1);
                    cond_stop(); cond_start();
                    send(hw); send(lo);
                    cond_rstart();
                    chk("R11", "addressed held over Sr", addressed, 1'b1);
                    chk("R4", "ack cleared by Sr", ack, 1'b0);
                    send(b[7:0]);
                    chk("R6", "Sr first byte ack", ack, (b == hr) || (b == hw) || gc_hit);
                    chk("R6", "tx after Sr read", tx_mode, (b == hr));
                    if (b != hw)
                        chk("R11", "addressed after Sr byte", addressed, (b == hr) || gc_hit);
                    if (b == hw) send(lo);
                    cond_rstart();
                    send(hr);
                    chk("R11", "read after second Sr", ack, (b == hr) || (b == hw));
                    chk("R11", "tx after second Sr", tx_mode, (b == hr) || (b == hw));
                end
            end
        end

        // Hold and STOP behaviour.
        gc_enable = 1'b0;
        own_addr  = 10'h2A5;
        hw = {5'b11110, own_addr[9:8], 1'b0};
        hr = {5'b11110, own_addr[9:8], 1'b1};
        cond_stop(); cond_start();
        send(hw); send(own_addr[7:0]);
        cond_rstart(); send(hr);
        repeat (3) @(negedge clk);
        chk("R4", "ack held without strobe", ack, 1'b1);
        chk("R6", "tx held", tx_mode, 1'b1);
        cond_stop();
        chk("R5", "ack after STOP", ack, 1'b0);
        chk("R5", "addressed after STOP", addressed, 1'b0);
        chk("R5", "tx after STOP", tx_mode, 1'b0);
        cond_rstart(); send(hr);
        chk("R5", "read after STOP needs new match", ack, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule